// File: doc/BRIEF.md
# Master Clock Ratio Detector

This block sits in a slave-only audio serial port and runs from the master clock. It counts master-clock cycles between rising edges of the left/right frame clock and bit-clock rising edges within the same frame. From these counts it decides whether the master clock runs at 256 or 384 times the sample rate. It then reports that ratio and the bit-clock count per frame that goes with it: 64 for the 256 ratio and 48 for the 384 ratio. No configuration pin is involved.

Once it has locked, the block tracks each frame length against the expected value. If a frame edge arrives more than a fixed tolerance (10 master-clock cycles by default) early, or fails to arrive within that tolerance, the block drops lock. It then emits a one-cycle resynchronisation reset for the rest of the port and starts detection again from scratch.

Both the frame clock and the bit clock pass through two-flop synchronisers into the master-clock domain before edge detection. The block is reset synchronously with an active-high reset.

Top module: `mclk_ratio_detect`

## Requirements
- R1: During and after a synchronous reset, with no LRCLK edge yet, `locked` and `resync_rst` are 0, `ratio_code` is 0 and `bits_per_frame` is 0.
- R2: Two consecutive measured frames of exactly 256 MCLK cycles, each holding 64 SCLK rising edges, set `locked` to 1, `ratio_code` to 1 and `bits_per_frame` to 64. These values appear on the third MCLK rising edge after the LRCLK rise that closes the second frame.
- R3: Two consecutive measured frames of exactly 384 MCLK cycles, each holding 48 SCLK rising edges, set `locked` to 1, `ratio_code` to 2 and `bits_per_frame` to 48, with the same timing as R2.
- R4: The first LRCLK rise after reset or after a fault only starts a measurement. A frame counts only between two LRCLK rises seen after that point.
- R5: A frame whose MCLK length is 256 or 384 but whose SCLK rise count is not the matching 64 or 48 never contributes to lock.
- R6: Frame lengths other than 256 or 384 do not lock. Frames alternating between 256/64 and 384/48 do not lock either, because the two matching frames must agree.
- R7: While locked, a frame whose length is within ±10 MCLK cycles of the expected length keeps `locked` at 1 and `ratio_code` unchanged, and gives no reset pulse.
- R8: While locked, an LRCLK rise closing a frame shorter than the expected length minus 10 makes `resync_rst` high on the third MCLK rising edge after that LRCLK rise. In the same cycle `locked`, `ratio_code` and `bits_per_frame` go to 0.
- R9: While locked, if expected length plus 11 MCLK cycles pass without an LRCLK rise, the fault of R8 is raised. The pulse appears on MCLK edge D+E+13, where D is the edge on which the last LRCLK rise was first sampled and E is the expected length.
- R10: `resync_rst` is never high for two consecutive cycles, and it is raised only from the locked state.
- R11: Asserting `rst` while locked clears `locked`, `ratio_code` and `bits_per_frame` on the next MCLK edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock (MCLK); all logic runs on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sclk_in | input | 1 | Bit clock, synchronous to MCLK, synchronised before use |
| lrclk_in | input | 1 | Left/right frame clock, synchronised before use |
| ratio_code | output | 2 | 0 none, 1 for 256 fs, 2 for 384 fs |
| bits_per_frame | output | 7 | Bit clocks per frame matching the ratio (64, 48 or 0) |
| locked | output | 1 | High while a ratio is established |
| resync_rst | output | 1 | One-cycle reset request on a frame phase fault |

## Verification
Lock, edge fault and reset-pulse results are due on the third MCLK rising edge after the LRCLK change that causes them: two synchroniser flops plus the output register. A missing edge is due E+13 edges after the last LRCLK rise was driven. The driver records the MCLK edge index at which each LRCLK rise is applied and pushes the expected event with its due index into a queue. The monitor samples on the falling edge, and whenever `locked` rises or `resync_rst` is seen it pops the next entry and compares the cycle index, ratio and bit count. Any surplus or missing event is therefore caught at its exact cycle, not just eventually.

// File: rtl/mclk_ratio_pkg.sv
package mclk_ratio_pkg;

    localparam int MEAS_W = 12;

    typedef logic [MEAS_W-1:0] meas_t;

    typedef enum logic [1:0] {
        RATIO_NONE = 2'd0,
        RATIO_LO   = 2'd1,
        RATIO_HI   = 2'd2
    } ratio_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HUNT = 2'd1,
        ST_LOCK = 2'd2
    } lock_st_e;

    // One frame measurement, valid when closed is high
    typedef struct packed {
        logic  closed;
        meas_t mclk_len;
        meas_t sclk_bits;
    } frame_meas_t;

    function automatic meas_t sat_inc(meas_t v);
        return (&v) ? v : v + 1'b1;
    endfunction

    function automatic meas_t abs_diff(meas_t a, meas_t b);
        return (a > b) ? a - b : b - a;
    endfunction

endpackage

// File: rtl/mrd_sync_edge.sv
module mrd_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic rise
);
    logic [STAGES:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) pipe <= '0;
        else     pipe <= {pipe[STAGES-1:0], d};
    end

    assign rise = pipe[STAGES-1] & ~pipe[STAGES];
endmodule

// File: rtl/mrd_frame_count.sv
module mrd_frame_count
    import mclk_ratio_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        lr_rise,
    input  logic        sck_rise,
    output frame_meas_t meas
);
    meas_t mcnt;
    meas_t scnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            mcnt <= '0;
            scnt <= '0;
        end else if (lr_rise) begin
            mcnt <= '0;
            scnt <= '0;
        end else begin
            mcnt <= sat_inc(mcnt);
            if (sck_rise) scnt <= sat_inc(scnt);
        end
    end

    always_comb begin
        meas.closed    = lr_rise;
        meas.mclk_len  = sat_inc(mcnt);
        meas.sclk_bits = sck_rise ? sat_inc(scnt) : scnt;
    end
endmodule

// File: rtl/mrd_lock_fsm.sv
module mrd_lock_fsm
    import mclk_ratio_pkg::*;
#(
    parameter int LO_MCLK = 256,
    parameter int HI_MCLK = 384,
    parameter int LO_BITS = 64,
    parameter int HI_BITS = 48,
    parameter int TOL     = 10
) (
    input  logic        clk,
    input  logic        rst,
    input  frame_meas_t meas,
    output logic        locked,
    output ratio_e      ratio,
    output logic        resync
);
    localparam meas_t LO_LEN = MEAS_W'(LO_MCLK);
    localparam meas_t HI_LEN = MEAS_W'(HI_MCLK);
    localparam meas_t LO_B   = MEAS_W'(LO_BITS);
    localparam meas_t HI_B   = MEAS_W'(HI_BITS);
    localparam meas_t TOL_M  = MEAS_W'(TOL);

    lock_st_e state;
    ratio_e   cand;
    ratio_e   cur;
    ratio_e   hit;
    meas_t    exp_len;
    logic     fault;

    always_comb begin
        hit = RATIO_NONE;
        if (meas.mclk_len == LO_LEN && meas.sclk_bits == LO_B)
            hit = RATIO_LO;
        else if (meas.mclk_len == HI_LEN && meas.sclk_bits == HI_B)
            hit = RATIO_HI;
        exp_len = (cur == RATIO_HI) ? HI_LEN : LO_LEN;
        // early edge, late edge, or no edge within the window
        fault = (state == ST_LOCK) &&
                ((meas.closed && abs_diff(meas.mclk_len, exp_len) > TOL_M) ||
                 (meas.mclk_len > exp_len + TOL_M));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            cand   <= RATIO_NONE;
            cur    <= RATIO_NONE;
            resync <= 1'b0;
        end else begin
            resync <= 1'b0;
            case (state)
                ST_IDLE: if (meas.closed) begin
                    state <= ST_HUNT;
                    cand  <= RATIO_NONE;
                end
                ST_HUNT: if (meas.closed) begin
                    if (hit != RATIO_NONE && hit == cand) begin
                        state <= ST_LOCK;
                        cur   <= hit;
                    end else begin
                        cand <= hit;
                    end
                end
                ST_LOCK: if (fault) begin
                    state  <= ST_IDLE;
                    cand   <= RATIO_NONE;
                    cur    <= RATIO_NONE;
                    resync <= 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign locked = (state == ST_LOCK);
    assign ratio  = cur;
endmodule

// File: rtl/mclk_ratio_detect.sv
module mclk_ratio_detect
    import mclk_ratio_pkg::*;
#(
    parameter int LO_MCLK     = 256,
    parameter int HI_MCLK     = 384,
    parameter int LO_BITS     = 64,
    parameter int HI_BITS     = 48,
    parameter int TOL         = 10,
    parameter int SYNC_STAGES = 2,
    localparam int BPF_W = $clog2(((LO_BITS > HI_BITS) ? LO_BITS : HI_BITS) + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sclk_in,
    input  logic             lrclk_in,
    output logic [1:0]       ratio_code,
    output logic [BPF_W-1:0] bits_per_frame,
    output logic             locked,
    output logic             resync_rst
);
    localparam int N_IN = 2;

    logic [N_IN-1:0] raw_in;
    logic [N_IN-1:0] edge_rise;
    logic            lr_rise;
    logic            sck_rise;
    frame_meas_t     meas;
    ratio_e          ratio;

    assign raw_in = {sclk_in, lrclk_in};

    generate
        for (genvar g = 0; g < N_IN; g++) begin : g_sync
            mrd_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
                .clk  (clk),
                .rst  (rst),
                .d    (raw_in[g]),
                .rise (edge_rise[g])
            );
        end
    endgenerate

    assign lr_rise  = edge_rise[0];
    assign sck_rise = edge_rise[1];

    mrd_frame_count u_count (
        .clk      (clk),
        .rst      (rst),
        .lr_rise  (lr_rise),
        .sck_rise (sck_rise),
        .meas     (meas)
    );

    mrd_lock_fsm #(
        .LO_MCLK (LO_MCLK),
        .HI_MCLK (HI_MCLK),
        .LO_BITS (LO_BITS),
        .HI_BITS (HI_BITS),
        .TOL     (TOL)
    ) u_fsm (
        .clk    (clk),
        .rst    (rst),
        .meas   (meas),
        .locked (locked),
        .ratio  (ratio),
        .resync (resync_rst)
    );

    always_comb begin
        ratio_code = ratio;
        case (ratio)
            RATIO_LO: bits_per_frame = BPF_W'(LO_BITS);
            RATIO_HI: bits_per_frame = BPF_W'(HI_BITS);
            default:  bits_per_frame = '0;
        endcase
    end
endmodule

// File: rtl/mclk_ratio_detect_chk.sv
module mclk_ratio_detect_chk (
    input logic       clk,
    input logic       rst,
    input logic       locked,
    input logic       resync_rst,
    input logic [1:0] ratio_code,
    input logic       lr_rise
);
    assert_pulse_single_R10: assert property (@(posedge clk) disable iff (rst)
        resync_rst |=> !resync_rst);

    assert_pulse_from_lock_R10: assert property (@(posedge clk) disable iff (rst)
        resync_rst |-> $past(locked));

    assert_pulse_drops_lock_R8: assert property (@(posedge clk) disable iff (rst)
        resync_rst |-> !locked);

    assert_lock_on_edge_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> $past(lr_rise));

    assert_ratio_held_R7: assert property (@(posedge clk) disable iff (rst)
        (locked && $past(locked)) |-> $stable(ratio_code));

    assert_ratio_when_locked_R3: assert property (@(posedge clk) disable iff (rst)
        locked |-> (ratio_code != 2'd0));
endmodule

bind mclk_ratio_detect mclk_ratio_detect_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .locked     (locked),
    .resync_rst (resync_rst),
    .ratio_code (ratio_code),
    .lr_rise    (lr_rise)
);

// File: tb/mclk_ratio_detect_tb.sv
module mclk_ratio_detect_tb;
    localparam int TOL = 10;
    localparam int LO  = 256;
    localparam int HI  = 384;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sclk_in = 1'b0;
    logic       lrclk_in = 1'b0;
    logic [1:0] ratio_code;
    logic [6:0] bits_per_frame;
    logic       locked;
    logic       resync_rst;

    always #10 clk = ~clk;

    mclk_ratio_detect u_dut (
        .clk            (clk),
        .rst            (rst),
        .sclk_in        (sclk_in),
        .lrclk_in       (lrclk_in),
        .ratio_code     (ratio_code),
        .bits_per_frame (bits_per_frame),
        .locked         (locked),
        .resync_rst     (resync_rst)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0;
    int n_bad = 0;
    int last_d = 0;
    bit done = 0;

    typedef struct {
        int    kind;   // 1 lock, 2 reset pulse
        int    at;
        int    rc;
        int    bits;
        string req;
    } evt_t;
    evt_t exp_q[$];

    task automatic check(string req, string what, int act, int expv);
        n_chk++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic push(int kind, int at, int rc, int bits, string req);
        evt_t e;
        e.kind = kind; e.at = at; e.rc = rc; e.bits = bits; e.req = req;
        exp_q.push_back(e);
    endtask

    // One frame: LRCLK rises at i==0 and is high for the first half
    task automatic run_frame(int len, int sper, int evt, int rc, int bits, string req);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            lrclk_in = (i < len / 2);
            sclk_in  = ((i % sper) < sper / 2);
            if (i == 0) begin
                last_d = cyc + 1;
                if (evt != 0) push(evt, last_d + 2, rc, bits, req);
            end
        end
    endtask

    task automatic hold_low(int n, int sper);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            lrclk_in = 1'b0;
            sclk_in  = ((i % sper) < sper / 2);
        end
    endtask

    task automatic observe(int kind);
        evt_t e;
        if (exp_q.size() == 0) begin
            check(kind == 1 ? "R6" : "R10", "unexpected event kind", kind, 0);
        end else begin
            e = exp_q.pop_front();
            check(e.req, "event kind", kind, e.kind);
            check(e.req, "event cycle", cyc, e.at);
            check(e.req, "ratio_code", int'(ratio_code), e.rc);
            check(e.req, "bits_per_frame", int'(bits_per_frame), e.bits);
        end
    endtask

    // Monitor / scoreboard
    logic prev_locked = 1'b0;
    logic prev_pulse  = 1'b0;
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (prev_pulse) check("R10", "pulse width", int'(resync_rst), 0);
            if (locked && !prev_locked) observe(1);
            if (resync_rst) observe(2);
        end
        prev_locked = locked;
        prev_pulse  = resync_rst;
    end

    initial begin
        repeat (4) @(negedge clk);
        check("R1", "locked in reset", int'(locked), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "locked", int'(locked), 0);
        check("R1", "resync_rst", int'(resync_rst), 0);
        check("R1", "ratio_code", int'(ratio_code), 0);
        check("R1", "bits_per_frame", int'(bits_per_frame), 0);

        // 256 fs: arm (R4), candidate, lock
        run_frame(LO, 4, 0, 0, 0, "");
        run_frame(LO, 4, 0, 0, 0, "");
        run_frame(LO, 4, 1, 1, 64, "R2");
        // jitter inside the window (R7)
        run_frame(LO + TOL, 4, 0, 0, 0, "");
        run_frame(LO - TOL, 4, 0, 0, 0, "");
        run_frame(LO, 4, 0, 0, 0, "");
        check("R7", "locked after jitter", int'(locked), 1);
        check("R7", "ratio after jitter", int'(ratio_code), 1);
        // early edge fault (R8)
        run_frame(LO - TOL - 1, 4, 0, 0, 0, "");
        run_frame(LO, 4, 2, 0, 0, "R8");
        // fault edge must not arm (R4)
        run_frame(LO, 4, 0, 0, 0, "");
        run_frame(LO, 4, 0, 0, 0, "");
        run_frame(LO, 4, 1, 1, 64, "R4");
        check("R4", "relocked", int'(locked), 1);

        // synchronous reset mid-lock (R11)
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R11", "locked", int'(locked), 0);
        check("R11", "ratio_code", int'(ratio_code), 0);
        check("R11", "bits_per_frame", int'(bits_per_frame), 0);
        rst = 1'b0;

        // 384 fs lock (R3), then missing edge (R9)
        run_frame(HI, 8, 0, 0, 0, "");
        run_frame(HI, 8, 0, 0, 0, "");
        run_frame(HI, 8, 1, 2, 48, "R3");
        push(2, last_d + HI + TOL + 3, 0, 0, "R9");
        hold_low(600, 8);
        check("R9", "locked after timeout", int'(locked), 0);

        // wrong bit-clock counts (R5)
        for (int k = 0; k < 5; k++) run_frame(LO, 8, 0, 0, 0, "");
        for (int k = 0; k < 5; k++) run_frame(HI, 4, 0, 0, 0, "");
        check("R5", "locked with bad sclk", int'(locked), 0);

        // unsupported and alternating lengths (R6)
        for (int k = 0; k < 4; k++) run_frame(300, 4, 0, 0, 0, "");
        check("R6", "locked at 300", int'(locked), 0);
        for (int k = 0; k < 3; k++) begin
            run_frame(LO, 4, 0, 0, 0, "");
            run_frame(HI, 8, 0, 0, 0, "");
        end
        hold_low(20, 4);
        check("R6", "locked alternating", int'(locked), 0);

        check("R8", "pending events", exp_q.size(), 0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL R1 watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule